// File: doc/BRIEF.md
# Concurrent Two-Tank Fill and Drain Sequencer

This block is a synchronous discrete-event controller for a pair of tanks. Each tank has a pump, a drain valve, a sensor that reports an empty tank and a sensor that reports a full tank. The controller rests in a single initial step until an operator presses a start button. The press then forks control into one branch per tank. From there, each branch fills its tank until the full sensor trips and then drains it until the empty sensor trips. It repeats this cycle indefinitely, with no coupling to the other branch.

The logic is a step chart with one flip-flop for each step. A step is set when its upstream step is active and that step's transition input is true. The step is cleared on the same edge on which its successor is set, so each branch keeps exactly one active step. The pump and valve enables come straight from the step flip-flops and are therefore registered. The whole step vector is also brought out for observation. The number of tanks is a parameter, and each tank gets an identical branch.

Top module: `tank_pair_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the controller enters the initial step. After reset, `step_vec` equals 1 (bit 0 is the initial step), and all `pump_en` and `valve_en` bits are 0.
- R2: In the initial step, sensor inputs have no effect and the step vector does not change until `start_btn` is sampled high.
- R3: When `start_btn` is sampled high in the initial step, the initial step clears and every branch's wait step sets. For tank t the wait step is `step_vec` bit 1+3t, the fill step is bit 2+3t and the drain step is bit 3+3t. If the tank then reads empty, its pump turns on at the next edge.
- R4: `pump_en[t]` is high exactly while the fill step of tank t is active. It stays high until `tank_full[t]` is sampled high and falls on that edge.
- R5: The edge on which the full sensor ends filling also sets the drain step, so `valve_en[t]` rises in the same cycle that `pump_en[t]` falls.
- R6: While draining, `tank_empty[t]` sampled high closes the valve and re-enters the fill step on the same edge, so each tank cycles fill and drain continuously.
- R7: After the fork, each branch has exactly one active step among its three step bits.
- R8: The pump and the valve of the same tank are never enabled in the same cycle.
- R9: Once the branches run, `start_btn` is ignored. The initial step is entered again only through reset.
- R10: The branches share no state. A tank whose full sensor never trips keeps pumping, while the other tank goes on cycling with unchanged timing. Tanks with different fill and drain times run out of phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_btn | input | 1 | Start push-button |
| tank_empty | input | NUM_TANKS | Per tank: 1 when the tank holds no water |
| tank_full | input | NUM_TANKS | Per tank: 1 when the tank has reached full level |
| pump_en | output | NUM_TANKS | Per tank pump enable |
| valve_en | output | NUM_TANKS | Per tank drain valve enable |
| step_vec | output | 1+3*NUM_TANKS | Active steps: bit 0 initial, then wait, fill and drain per tank |

## Verification
A wrong internal step would show at the ports one edge after the transition that caused it. The symptoms would be a pump or valve pulse of the wrong length, or a valve that does not rise in the cycle its pump falls. Other symptoms would be two bits active in one branch's slice of the step vector, or an initial step that comes back without reset. The bench drives the block from a behavioural model of both tanks and sweeps a grid of tank capacities. Pump pulses must last capacity plus one cycles and valve pulses capacity plus two cycles, so a fault in any step is caught within the first fill and drain period of that tank.

// File: rtl/tank_seq_pkg.sv
package tank_seq_pkg;
  localparam int STEPS_PER_BRANCH = 3;

  typedef struct packed {
    logic drain;
    logic fill;
    logic armed;
  } branch_steps_t;
endpackage

// File: rtl/tank_seq_init_step.sv
module tank_seq_init_step (
  input  logic clk,
  input  logic rst,
  input  logic start_btn,
  output logic active,
  output logic fork_go
);
  assign fork_go = active & start_btn;

  always_ff @(posedge clk) begin
    if (rst)          active <= 1'b1;
    else if (fork_go) active <= 1'b0;
  end
endmodule

// File: rtl/tank_seq_branch.sv
module tank_seq_branch
  import tank_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          fork_go,
  input  logic          is_empty,
  input  logic          is_full,
  output branch_steps_t steps
);
  logic set_fill, set_drain;

  assign set_fill  = (steps.armed | steps.drain) & is_empty;
  assign set_drain = steps.fill & is_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      steps <= '0;
    end else begin
      if (fork_go)       steps.armed <= 1'b1;
      else if (set_fill) steps.armed <= 1'b0;

      if (set_fill)       steps.fill <= 1'b1;
      else if (set_drain) steps.fill <= 1'b0;

      if (set_drain)     steps.drain <= 1'b1;
      else if (set_fill) steps.drain <= 1'b0;
    end
  end
endmodule

// File: rtl/tank_pair_seq.sv
module tank_pair_seq
  import tank_seq_pkg::*;
#(
  parameter int NUM_TANKS = 2,
  localparam int STEP_W = 1 + STEPS_PER_BRANCH * NUM_TANKS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_btn,
  input  logic [NUM_TANKS-1:0] tank_empty,
  input  logic [NUM_TANKS-1:0] tank_full,
  output logic [NUM_TANKS-1:0] pump_en,
  output logic [NUM_TANKS-1:0] valve_en,
  output logic [STEP_W-1:0]    step_vec
);
  logic init_active, fork_go;

  tank_seq_init_step u_init (
    .clk       (clk),
    .rst       (rst),
    .start_btn (start_btn),
    .active    (init_active),
    .fork_go   (fork_go)
  );

  assign step_vec[0] = init_active;

  for (genvar t = 0; t < NUM_TANKS; t++) begin : g_branch
    branch_steps_t bs;

    tank_seq_branch u_br (
      .clk      (clk),
      .rst      (rst),
      .fork_go  (fork_go),
      .is_empty (tank_empty[t]),
      .is_full  (tank_full[t]),
      .steps    (bs)
    );

    assign pump_en[t]  = bs.fill;
    assign valve_en[t] = bs.drain;
    assign step_vec[1 + STEPS_PER_BRANCH*t +: STEPS_PER_BRANCH] = bs;
  end
endmodule

// File: rtl/tank_seq_checker.sv
module tank_seq_checker #(
  parameter int NUM_TANKS = 2,
  localparam int STEP_W = 1 + 3 * NUM_TANKS
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start_btn,
  input logic [NUM_TANKS-1:0] tank_empty,
  input logic [NUM_TANKS-1:0] tank_full,
  input logic [NUM_TANKS-1:0] pump_en,
  input logic [NUM_TANKS-1:0] valve_en,
  input logic [STEP_W-1:0]    step_vec
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    step_vec[0] && !start_btn |=> step_vec[0]); // R2

  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
    !step_vec[0] |=> !step_vec[0]); // R9

  for (genvar t = 0; t < NUM_TANKS; t++) begin : g_chk
    AST_FORK_ARMS: assert property (@(posedge clk) disable iff (rst)
      step_vec[0] && start_btn |=> step_vec[1+3*t] && !step_vec[0]); // R3

    AST_FILL_TO_DRAIN: assert property (@(posedge clk) disable iff (rst)
      pump_en[t] && tank_full[t] |=> valve_en[t] && !pump_en[t]); // R5

    AST_DRAIN_TO_FILL: assert property (@(posedge clk) disable iff (rst)
      valve_en[t] && tank_empty[t] |=> pump_en[t] && !valve_en[t]); // R6

    AST_BRANCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      !step_vec[0] |-> $countones(step_vec[1+3*t +: 3]) == 1); // R7

    AST_PUMP_VALVE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(pump_en[t] && valve_en[t])); // R8
  end
endmodule

bind tank_pair_seq tank_seq_checker #(.NUM_TANKS(NUM_TANKS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_btn  (start_btn),
  .tank_empty (tank_empty),
  .tank_full  (tank_full),
  .pump_en    (pump_en),
  .valve_en   (valve_en),
  .step_vec   (step_vec)
);

// File: tb/tank_pair_seq_bench.sv
`timescale 1ns/1ps
module tank_pair_seq_bench;
  localparam int NT = 2;
  localparam int SW = 1 + 3 * NT;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, start = 1'b0;
  logic [NT-1:0] empty, full, pump, valve;
  logic [SW-1:0] step;

  int tests = 0, fails = 0;
  int lvl [NT] = '{0, 0};
  int cap [NT] = '{3, 4};
  bit stall1 = 1'b0, mon_on = 1'b0, excl_bad, onehot_bad, saw_diff;
  int pw [NT], vw [NT], np [NT], nv [NT];
  logic [NT-1:0] pump_q;

  tank_pair_seq #(.NUM_TANKS(NT)) u_tank_pair_seq (
    .clk(clk), .rst(rst), .start_btn(start), .tank_empty(empty),
    .tank_full(full), .pump_en(pump), .valve_en(valve), .step_vec(step));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural plant: one level unit per cycle in or out
  always @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (rst) lvl[t] <= 0;
      else if (pump[t]) lvl[t] <= lvl[t] + 1;
      else if (valve[t] && lvl[t] > 0) lvl[t] <= lvl[t] - 1;
    end
  end

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      empty[t] = (lvl[t] == 0);
      full[t]  = (lvl[t] >= cap[t]) && !(t == 1 && stall1);
    end
  end

  // pulse-width monitor
  always @(negedge clk) begin
    if (!mon_on) begin
      for (int t = 0; t < NT; t++) begin pw[t] = 0; vw[t] = 0; np[t] = 0; nv[t] = 0; end
      pump_q = '0;
    end else begin
      if ((pump & valve) != 0) excl_bad = 1'b1;
      if (pump[0] != pump[1]) saw_diff = 1'b1;
      for (int t = 0; t < NT; t++) begin
        if (!step[0] && $countones(step[1+3*t +: 3]) != 1) onehot_bad = 1'b1;
        if (pump_q[t] && !pump[t]) check(valve[t] == 1'b1, "R5 valve rises as pump falls", valve[t], 1);
        if (pump[t]) pw[t]++;
        else if (pw[t] > 0) begin
          check(pw[t] == cap[t] + 1, "R4 pump pulse width", pw[t], cap[t] + 1);
          np[t]++; pw[t] = 0;
        end
        if (valve[t]) vw[t]++;
        else if (vw[t] > 0) begin
          check(vw[t] == cap[t] + 2, "R6 valve pulse width", vw[t], cap[t] + 2);
          nv[t]++; vw[t] = 0;
        end
      end
      pump_q = pump;
    end
  end

  task automatic wait_pulses(input int n0, input int n1);
    int guard = 0;
    while ((nv[0] < n0 || nv[1] < n1) && guard < 3000) begin
      @(negedge clk); guard++;
    end
    check(guard < 3000, "R6 continuous cycling", guard, 0);
  endtask

  task automatic run(input int c0, input int c1, input bit stall);
    logic [SW-1:0] arm_exp = '0;
    for (int t = 0; t < NT; t++) arm_exp[1+3*t] = 1'b1;
    cap[0] = c0; cap[1] = c1; stall1 = 1'b0;
    mon_on = 1'b0; excl_bad = 0; onehot_bad = 0; saw_diff = 0;
    @(negedge clk); rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(step == 1 && pump == 0 && valve == 0, "R1 reset state", int'(step), 1);
    repeat (5) @(negedge clk);
    check(step == 1 && pump == 0, "R2 idle before start", int'(step), 1);
    start = 1'b1; mon_on = 1'b1; stall1 = stall;
    @(negedge clk); start = 1'b0;
    check(step == arm_exp && pump == 0, "R3 fork to wait steps", int'(step), int'(arm_exp));
    @(negedge clk);
    check(pump == {NT{1'b1}}, "R3 pumps start on empty", int'(pump), (1 << NT) - 1);
    if (!stall) begin
      wait_pulses(2, 2);
      start = 1'b1; @(negedge clk); start = 1'b0;
      check(step[0] == 1'b0, "R9 start ignored while running", step[0], 0);
      wait_pulses(4, 4);
      check(saw_diff == (c0 != c1), "R10 branches out of phase", saw_diff, c0 != c1);
    end else begin
      wait_pulses(3, 0);
      check(pump[1] == 1'b1 && nv[1] == 0, "R10 stalled tank keeps pumping", pump[1], 1);
    end
    check(!excl_bad, "R8 pump and valve exclusive", excl_bad, 0);
    check(!onehot_bad, "R7 one step per branch", onehot_bad, 0);
  endtask

  initial begin
    for (int c0 = 2; c0 <= 5; c0++)
      for (int c1 = 3; c1 <= 6; c1++)
        run(c0, c1, 1'b0);
    run(4, 3, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule